// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupts

This block is a performance monitoring unit with sixteen 48-bit event counters. Each counter is bound by an 8-bit select code to one of 256 single-cycle event strobes. On every clock where the unit is switched on, the counter itself is enabled and its chosen strobe is high, the counter advances by one. Software reaches the block through a plain 32-bit write/read register port. Reads are combinational from the address.

When a counter passes its top value it wraps to zero and latches a sticky overflow flag. Each flag can be routed to one level interrupt line or held back by a mask bit. Software drops a flag by writing a one to its position in a clear register. A counter can be preset through its two 32-bit words, and a preset beats a same-cycle event.

Top module: `evt_cnt_bank`

## Requirements
- R1: After reset all counters, the global enable, the per-counter enables and all overflow flags are zero. Every mask bit is 1, so register 0x0804 reads 0x0000FFFF. Every select code is 0xFF, so each of 0x1E80..0x1E8C reads 0xFFFFFFFF. The interrupt output is low.
- R2: Counter n advances by exactly one on a clock where three things hold: bit 0 of register 0x1E00 is 1, bit n of register 0x1E04 is 1, and `evt_in[code]` is high. Clearing bit n stops only counter n.
- R3: While bit 0 of 0x1E00 is 0, no counter changes except by a software write.
- R4: A counter whose select code is 0xFF never advances, even when `evt_in[255]` is high.
- R5: Counter n takes its code from the word at 0x1E80 + 4*(n/4), in bits [8*(n%4)+7 : 8*(n%4)].
- R6: Counter n has a 64-bit slot at 0x1F00 + 8*n. A write to the low word (+0) loads bits 31:0. A write to the high word (+4) loads bits 47:32 from write data bits 15:0. Bits 63:48 read as zero and ignore writes.
- R7: An increment from 2^48-1 leaves the counter at zero. The same clock edge sets bit n of the status register 0x0808.
- R8: A status bit stays set until it is cleared, whether or not it is masked. The interrupt is high exactly when some status bit is 1 and its bit in the mask register 0x0804 is 0.
- R9: Writing 1 to bit n of 0x080C clears status bit n. Writing 0 leaves the bit unchanged. The register reads as zero.
- R10: If a software write to a counter word and an increment of that counter fall in the same cycle, the written value is loaded and the increment is lost.
- R11: If an overflow and a clear of the same status bit fall in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 16 | Byte address of the 32-bit word being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | 256 | Event strobes, one per event code |
| irq | output | 1 | Level interrupt: any unmasked overflow flag |

## Verification
The bench targets the wrap from the all-ones value. A design that saturates, or that flags one cycle late, leaves a nonzero count or a missing status bit. It also targets a preset and an event in the same cycle, where a wrong priority shows up as an off-by-one count. It drives overflow and clear of the same bit together, where a wrong order silently loses an overflow. It writes a zero to the clear register, which a design that writes the value instead of clearing bits would use to wipe the flags. Further checks cover the high-word upper bits, code 0xFF with strobe 255 active, and per-counter gating. A random phase compares every counter against a bench model after hundreds of mixed events and interrupt-register writes.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;
    localparam int          BUS_W         = 32;
    localparam logic [15:0] ADR_IRQ_MASK  = 16'h0804;
    localparam logic [15:0] ADR_IRQ_STAT  = 16'h0808;
    localparam logic [15:0] ADR_IRQ_CLR   = 16'h080C;
    localparam logic [15:0] ADR_CTRL      = 16'h1E00;
    localparam logic [15:0] ADR_CNT_EN    = 16'h1E04;
    localparam logic [15:0] ADR_SEL_BASE  = 16'h1E80;
    localparam logic [15:0] ADR_SLOT_BASE = 16'h1F00;
endpackage

// File: rtl/evt_cnt_slice.sv
module evt_cnt_slice #(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);
    localparam int HI_W = CNT_W - 32;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } slice_t;

    slice_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        ovf = 1'b0;
        if (ld_lo) begin
            s_d.cnt[31:0] = wdata;
        end else if (ld_hi) begin
            s_d.cnt[CNT_W-1:32] = wdata[HI_W-1:0];
        end else if (inc) begin
            s_d.cnt = s_q.cnt + ONE;
            ovf     = &s_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_q = s_q.cnt;

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld_lo && !ld_hi && (&cnt_q)) |=> (cnt_q == '0)); // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (cnt_q[31:0] == $past(wdata))); // R10
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
    parameter int NUM_CNT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr,
    input  logic               clr_wr,
    input  logic [NUM_CNT-1:0] wdata,
    input  logic [NUM_CNT-1:0] ovf,
    output logic [NUM_CNT-1:0] mask_q,
    output logic [NUM_CNT-1:0] status_q,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_CNT-1:0] mask;
        logic [NUM_CNT-1:0] status;
    } irq_t;

    irq_t i_d, i_q;
    logic [NUM_CNT-1:0] clr_vec;

    always_comb begin
        i_d     = i_q;
        clr_vec = clr_wr ? wdata : '0;
        if (mask_wr) i_d.mask = wdata;
        i_d.status = (i_q.status & ~clr_vec) | ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q.mask   <= '1;
            i_q.status <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign mask_q   = i_q.mask;
    assign status_q = i_q.status;
    assign irq      = |(i_q.status & ~i_q.mask);

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~clr_vec) != '0) |=>
        ((status_q & $past(status_q & ~clr_vec)) == $past(status_q & ~clr_vec))); // R8
    AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf != '0) |=> ((status_q & $past(ovf)) == $past(ovf))); // R11
endmodule

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank
    import evt_bank_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int CNT_W   = 48,
    parameter int NUM_EVT = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [15:0]        bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);
    localparam int CODE_W    = $clog2(NUM_EVT);
    localparam int PER_WORD  = BUS_W / CODE_W;
    localparam int NUM_SEL   = NUM_CNT / PER_WORD;
    localparam int CIDX_W    = $clog2(NUM_CNT);
    localparam int SEL_BITS  = NUM_CNT * CODE_W;
    localparam logic [CODE_W-1:0] CODE_NONE = '1;

    typedef struct packed {
        logic                en;
        logic [NUM_CNT-1:0]  cen;
        logic [SEL_BITS-1:0] sel;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [15:0]         slot_off;
    logic                slot_hit;
    logic [CIDX_W-1:0]   slot_idx;
    logic                slot_hi;
    logic [NUM_CNT-1:0]  inc, ld_lo, ld_hi, ovf;
    logic [NUM_CNT-1:0]  mask_q, status_q;
    logic [CNT_W-1:0]    cnt_val [NUM_CNT];
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;

    // address decode of the counter slots
    always_comb begin
        slot_off = bus_addr - ADR_SLOT_BASE;
        slot_hit = (bus_addr >= ADR_SLOT_BASE) && (slot_off < 16'(NUM_CNT * 8))
                   && (bus_addr[1:0] == 2'b00);
        slot_idx = slot_off[3 +: CIDX_W];
        slot_hi  = slot_off[2];
    end

    // control register next state
    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            if (bus_addr == ADR_CTRL)   r_d.en  = bus_wdata[0];
            if (bus_addr == ADR_CNT_EN) r_d.cen = bus_wdata[NUM_CNT-1:0];
            for (int k = 0; k < NUM_SEL; k++) begin
                if (bus_addr == ADR_SEL_BASE + 16'(4 * k))
                    r_d.sel[k*BUS_W +: BUS_W] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en  <= 1'b0;
            r_q.cen <= '0;
            r_q.sel <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        logic [CODE_W-1:0] code;
        assign code     = r_q.sel[n*CODE_W +: CODE_W];
        assign inc[n]   = r_q.en && r_q.cen[n] && (code != CODE_NONE) && evt_in[code];
        assign ld_lo[n] = bus_wr && slot_hit && !slot_hi && (slot_idx == CIDX_W'(n));
        assign ld_hi[n] = bus_wr && slot_hit &&  slot_hi && (slot_idx == CIDX_W'(n));

        evt_cnt_slice #(.CNT_W(CNT_W)) i_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[n]),
            .ld_lo (ld_lo[n]),
            .ld_hi (ld_hi[n]),
            .wdata (bus_wdata),
            .cnt_q (cnt_val[n]),
            .ovf   (ovf[n])
        );
        assign cnt_flat[n*CNT_W +: CNT_W] = cnt_val[n];
    end

    evt_irq_ctrl #(.NUM_CNT(NUM_CNT)) i_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_wr  (bus_wr && (bus_addr == ADR_IRQ_MASK)),
        .clr_wr   (bus_wr && (bus_addr == ADR_IRQ_CLR)),
        .wdata    (bus_wdata[NUM_CNT-1:0]),
        .ovf      (ovf),
        .mask_q   (mask_q),
        .status_q (status_q),
        .irq      (irq)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_CTRL)     bus_rdata = {31'b0, r_q.en};
        if (bus_addr == ADR_CNT_EN)   bus_rdata = 32'(r_q.cen);
        if (bus_addr == ADR_IRQ_MASK) bus_rdata = 32'(mask_q);
        if (bus_addr == ADR_IRQ_STAT) bus_rdata = 32'(status_q);
        for (int k = 0; k < NUM_SEL; k++) begin
            if (bus_addr == ADR_SEL_BASE + 16'(4 * k))
                bus_rdata = r_q.sel[k*BUS_W +: BUS_W];
        end
        if (slot_hit) begin
            if (slot_hi) bus_rdata = 32'(cnt_val[slot_idx][CNT_W-1:32]);
            else         bus_rdata = cnt_val[slot_idx][31:0];
        end
    end

    AST_NO_COUNT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.en && !bus_wr) |=> $stable(cnt_flat)); // R3
endmodule

// File: tb/test_evt_cnt_bank.sv
`timescale 1ns/1ps
module test_evt_cnt_bank;
    localparam int N = 16;
    localparam time CLK_P = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [255:0] evt = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [47:0]  m_cnt [N];
    logic         m_en;
    logic [15:0]  m_cen, m_mask, m_st;
    logic [127:0] m_sel;

    always #(CLK_P/2) clk = ~clk;

    evt_cnt_bank i_evt_cnt_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt), .irq(irq)
    );

    function automatic bit is_slot(input logic [15:0] a);
        return (a >= 16'h1F00) && (a < 16'h1F80) && (a[1:0] == 2'b00);
    endfunction

    function automatic void model_reset();
        for (int n = 0; n < N; n++) m_cnt[n] = '0;
        m_en = 0; m_cen = '0; m_mask = '1; m_st = '0; m_sel = '1;
    endfunction

    function automatic void model_step(input bit wr, input logic [15:0] a,
                                       input logic [31:0] d, input logic [255:0] ev);
        logic [15:0] ovf = '0;
        logic [15:0] clr;
        for (int n = 0; n < N; n++) begin
            logic [7:0] code = m_sel[n*8 +: 8];
            bit inc = m_en && m_cen[n] && (code != 8'hFF) && ev[code];
            bit ld  = wr && is_slot(a) && (((a - 16'h1F00) >> 3) == 16'(n));
            if (ld) begin
                if (a[2]) m_cnt[n][47:32] = d[15:0];
                else      m_cnt[n][31:0]  = d;
            end else if (inc) begin
                if (m_cnt[n] == 48'hFFFF_FFFF_FFFF) begin
                    m_cnt[n] = '0; ovf[n] = 1'b1;
                end else m_cnt[n] = m_cnt[n] + 48'd1;
            end
        end
        clr  = (wr && a == 16'h080C) ? d[15:0] : 16'h0;
        m_st = (m_st & ~clr) | ovf;
        if (wr) begin
            if (a == 16'h0804) m_mask = d[15:0];
            if (a == 16'h1E00) m_en = d[0];
            if (a == 16'h1E04) m_cen = d[15:0];
            if (a >= 16'h1E80 && a <= 16'h1E8C && a[1:0] == 2'b00)
                m_sel[int'((a - 16'h1E80) >> 2) * 32 +: 32] = d;
        end
    endfunction

    function automatic logic [31:0] exp_read(input logic [15:0] a);
        if (a == 16'h0804) return {16'h0, m_mask};
        if (a == 16'h0808) return {16'h0, m_st};
        if (a == 16'h1E00) return {31'h0, m_en};
        if (a == 16'h1E04) return {16'h0, m_cen};
        if (a >= 16'h1E80 && a <= 16'h1E8C && a[1:0] == 2'b00)
            return m_sel[int'((a - 16'h1E80) >> 2) * 32 +: 32];
        if (is_slot(a)) begin
            int idx = int'((a - 16'h1F00) >> 3);
            return a[2] ? {16'h0, m_cnt[idx][47:32]} : m_cnt[idx][31:0];
        end
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic tick(input bit wr, input logic [15:0] a, input logic [31:0] d,
                        input logic [255:0] ev);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt = ev;
        model_step(wr, a, d, ev);
        @(posedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        tick(1'b1, a, d, '0);
    endtask

    task automatic rd(input string tag, input logic [15:0] a);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a; evt = '0;
        #1;
        check(tag, bus_rdata, exp_read(a));
    endtask

    task automatic chk_irq(input string tag);
        @(negedge clk);
        bus_wr = 1'b0; evt = '0;
        #1;
        check(tag, {31'h0, irq}, {31'h0, |(m_st & ~m_mask)});
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom();
        return v;
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd("R1 mask", 16'h0804);
        rd("R1 status", 16'h0808);
        rd("R1 select", 16'h1E80);
        rd("R1 select3", 16'h1E8C);
        rd("R1 ctrl", 16'h1E00);
        rd("R1 cnt0", 16'h1F00);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R3 global enable off
        wr(16'h1E80, 32'h0302_0100);
        wr(16'h1E04, 32'h0000_001F);
        repeat (5) tick(1'b0, 16'h0, 32'h0, '1);
        rd("R3 cnt0 frozen", 16'h1F00);
        rd("R3 cnt3 frozen", 16'h1F18);

        // R2 counting and per-counter enable
        wr(16'h1E00, 32'h1);
        repeat (3) tick(1'b0, 16'h0, 32'h0, 256'h5);
        rd("R2 cnt0", 16'h1F00);
        rd("R2 cnt1 idle", 16'h1F08);
        rd("R2 cnt2", 16'h1F10);
        wr(16'h1E04, 32'h0000_001D);
        repeat (2) tick(1'b0, 16'h0, 32'h0, '1);
        rd("R2 cnt1 disabled", 16'h1F08);
        rd("R2 cnt3", 16'h1F18);

        // R4 code 0xFF never counts
        rd("R4 cnt4", 16'h1F20);

        // R5 select field position
        wr(16'h1E84, 32'h0000_07FF);
        wr(16'h1E04, 32'h0000_003D);
        repeat (4) tick(1'b0, 16'h0, 32'h0, 256'h80);
        rd("R5 cnt5", 16'h1F28);
        rd("R5 select1", 16'h1E84);

        // R6 slot words
        wr(16'h1F0C, 32'hABCD_1234);
        wr(16'h1F08, 32'hDEAD_BEEF);
        rd("R6 hi upper zero", 16'h1F0C);
        rd("R6 lo", 16'h1F08);

        // R7 wrap, R8 masked sticky
        wr(16'h1F04, 32'h0000_FFFF);
        wr(16'h1F00, 32'hFFFF_FFFE);
        repeat (2) tick(1'b0, 16'h0, 32'h0, 256'h1);
        rd("R7 wrap lo", 16'h1F00);
        rd("R7 wrap hi", 16'h1F04);
        rd("R7 status", 16'h0808);
        chk_irq("R8 masked irq");
        wr(16'h0804, 32'h0000_FFFE);
        chk_irq("R8 unmasked irq");

        // R9 write-one-to-clear
        wr(16'h080C, 32'h0);
        rd("R9 zero no effect", 16'h0808);
        rd("R9 clear reads zero", 16'h080C);
        wr(16'h080C, 32'h1);
        rd("R9 cleared", 16'h0808);
        chk_irq("R9 irq low");

        // R10 write beats increment
        tick(1'b1, 16'h1F10, 32'h55, 256'h4);
        rd("R10 load wins", 16'h1F10);

        // R11 overflow beats clear
        wr(16'h1F04, 32'h0000_FFFF);
        wr(16'h1F00, 32'hFFFF_FFFF);
        tick(1'b1, 16'h080C, 32'h1, 256'h1);
        rd("R11 status", 16'h0808);
        chk_irq("R11 irq");

        // random phase: R2 R7 R8
        wr(16'h080C, 32'hFFFF);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] s;
            for (int j = 0; j < 4; j++)
                s[j*8 +: 8] = (($urandom() % 8) == 0) ? 8'hFF : 8'($urandom() % 24);
            wr(16'h1E80 + 16'(4 * k), s);
        end
        wr(16'h1E04, $urandom() | 32'h8);
        wr(16'h1F1C, 32'h0000_FFFF);
        wr(16'h1F18, 32'hFFFF_FFF0);
        wr(16'h0804, 32'($urandom() & 32'hFFFF));
        for (int c = 0; c < 400; c++) begin
            int r = int'($urandom() % 20);
            if (r == 0)      tick(1'b1, 16'h080C, $urandom(), rnd256());
            else if (r == 1) tick(1'b1, 16'h0804, $urandom(), rnd256());
            else if (r == 2) tick(1'b1, 16'h1E00, 32'($urandom() % 4 != 0), rnd256());
            else             tick(1'b0, 16'h0, 32'h0, rnd256());
        end
        for (int n = 0; n < N; n++) begin
            rd("R2 random lo", 16'h1F00 + 16'(8 * n));
            rd("R2 random hi", 16'h1F04 + 16'(8 * n));
        end
        rd("R7 random status", 16'h0808);
        chk_irq("R8 random irq");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule